// File: doc/BRIEF.md
# CCD Readout Pixel Region Tagger

This block follows the serial sample stream of a full-frame CCD and labels each sample with its position and the part of the sensor it came from. Downstream logic uses the labels to keep image samples, average dark samples for black level, watch the transfer-efficiency test columns and drop inactive samples. It takes three single-cycle inputs: a pixel strobe for each digitised sample, a line-start pulse and a frame-start pulse. For each strobe it returns the raw row and column, a region code, one flag for each region, image coordinates counted from 1, a flag for dark samples that may be contaminated, and a flag for the defect-exclusion border of the image.

All segment sizes are parameters. With the defaults a line has 4145 samples and a frame has 4128 lines. Counters saturate instead of wrapping. A line that ends before its last sample raises an error flag that stays set until reset.

Top module: `ccd_region_tagger`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `out_valid`, `short_line`, every flag, `row_idx`, `col_idx`, `img_x` and `img_y` are 0.
- R2: A strobe sampled at a rising edge is reported after that same edge with `out_valid` high. Successive strobes carry columns 0, 1, 2 and so on. A line-start pulse restarts the column at 0, and a strobe in the same cycle is tagged column 0.
- R3: A frame-start pulse sets row 0 and column 0. The first line-start after reset or after a frame start keeps row 0, and each later line-start adds 1 to the row.
- R4: Default column layout, with columns counted from 0: 0-10 invalid, 11 test, 12-14 invalid, 15-34 dark, 35 buffer, 36-4131 image, 4132 buffer, 4133-4141 dark, 4142 test, 4143-4144 invalid.
- R5: Default row layout: 0-19 dark, 20 buffer, 21-4116 image, 4117 buffer, 4118-4127 dark.
- R6: Region codes are image 0, dark 1, buffer 2, test 3 and invalid 4. When the row and column labels differ, priority runs invalid > test > dark > buffer > image. For a valid sample exactly the flag of its region is set: `flag_image`, `flag_dark`, `flag_buffer`, `flag_test` or `flag_invalid`.
- R7: Test columns 11 and 4142 carry code 3 in every row from 0 to 4127.
- R8: `near_dark` is set only on dark-region samples that lie in column 33, 34, 4133 or 4134, or in row 18, 19, 4118 or 4119. These are the two dark positions next to each buffer.
- R9: `defect_edge` is set only on image samples whose `img_x` or `img_y` is 1, 2, 4095 or 4096.
- R10: For image samples `img_x` = column - 35 and `img_y` = row - 20, both in the range 1 to 4096. For all other samples both are 0.
- R11: Strobes after column 4144 report column 4145 with code 4. Line-starts after row 4127 report row 4128, which also gets code 4. Neither counter wraps.
- R12: `short_line` is set when a line-start ends a started line that has had fewer than 4145 strobes. A line-start that follows a complete line leaves it clear. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | One serial sample present this cycle |
| line_start | input | 1 | Start of a new line |
| frame_start | input | 1 | Start of a new frame |
| out_valid | output | 1 | Tag outputs describe a strobe of the previous cycle |
| row_idx | output | 13 | Raw row counter, saturates at 4128 |
| col_idx | output | 13 | Raw column counter, saturates at 4145 |
| region | output | 3 | Region code |
| flag_image | output | 1 | Image sample |
| flag_dark | output | 1 | Dark reference sample |
| flag_buffer | output | 1 | Buffer sample |
| flag_test | output | 1 | Transfer-efficiency test column |
| flag_invalid | output | 1 | Inactive or out-of-range sample |
| near_dark | output | 1 | Dark sample possibly contaminated by nearby signal |
| defect_edge | output | 1 | Image sample in the excluded 2-pixel border |
| img_x | output | 13 | Image column counted from 1, else 0 |
| img_y | output | 13 | Image row counted from 1, else 0 |
| short_line | output | 1 | Sticky early-line-end error |

## Verification
Every tag is registered once, so a strobe taken at a rising edge shows up on the outputs right after that edge. `short_line` is updated at the edge that takes the line-start. The bench changes inputs only on falling edges and pushes the expected tag into a queue. A monitor reads the outputs at the next falling edge, pops the entries in order and compares them. The error flag is checked at the falling edge that follows the line-start.

// File: rtl/ccd_tag_pkg.sv
package ccd_tag_pkg;

    typedef enum logic [2:0] {
        RGN_IMAGE   = 3'd0,
        RGN_DARK    = 3'd1,
        RGN_BUFFER  = 3'd2,
        RGN_TEST    = 3'd3,
        RGN_INVALID = 3'd4
    } region_e;

    typedef enum logic [2:0] {
        AX_INV  = 3'd0,
        AX_TEST = 3'd1,
        AX_DARK = 3'd2,
        AX_BUF  = 3'd3,
        AX_IMG  = 3'd4
    } axis_e;

endpackage

// File: rtl/ccd_pos_counter.sv
module ccd_pos_counter #(
    parameter int COLS = 4145,
    parameter int ROWS = 4128,
    parameter int CW   = 13,
    parameter int RW   = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_stb,
    input  logic          line_start,
    input  logic          frame_start,
    output logic [RW-1:0] pos_row,
    output logic [CW-1:0] pos_col,
    output logic          short_line
);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          started;
        logic          short_err;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    cnt_t n;

    always_comb begin
        n = cnt_q;
        if (frame_start) begin
            n.row     = '0;
            n.col     = '0;
            n.started = 1'b0;
        end
        if (line_start) begin
            if (n.started) begin
                if (n.row != RW'(ROWS)) n.row = n.row + RW'(1);
                if (n.col != CW'(COLS)) n.short_err = 1'b1;
            end
            n.col     = '0;
            n.started = 1'b1;
        end
        pos_row = n.row;
        pos_col = n.col;
        if (pix_stb && (n.col != CW'(COLS))) n.col = n.col + CW'(1);
        cnt_d = n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign short_line = cnt_q.short_err;

endmodule

// File: rtl/ccd_col_class.sv
module ccd_col_class
    import ccd_tag_pkg::*;
#(
    parameter int LEAD_INV = 11,
    parameter int TEST_W   = 1,
    parameter int GAP_INV  = 3,
    parameter int DARK_L   = 20,
    parameter int BUF_W    = 1,
    parameter int IMG_W    = 4096,
    parameter int DARK_R   = 9,
    parameter int NEAR_W   = 2,
    parameter int EDGE_W   = 2,
    parameter int CW       = 13
) (
    input  logic [CW-1:0] col,
    output axis_e         cls,
    output logic          near,
    output logic          edge_hit,
    output logic [CW-1:0] off
);

    localparam int S_TA  = LEAD_INV;
    localparam int S_GAP = S_TA + TEST_W;
    localparam int S_DL  = S_GAP + GAP_INV;
    localparam int S_BL  = S_DL + DARK_L;
    localparam int S_IMG = S_BL + BUF_W;
    localparam int S_BR  = S_IMG + IMG_W;
    localparam int S_DR  = S_BR + BUF_W;
    localparam int S_TB  = S_DR + DARK_R;
    localparam int S_TL  = S_TB + TEST_W;

    int c;

    always_comb begin
        c        = int'(col);
        cls      = AX_INV;
        near     = 1'b0;
        edge_hit = 1'b0;
        off      = '0;
        if (c < S_TA) begin
            cls = AX_INV;
        end else if (c < S_GAP) begin
            cls = AX_TEST;
        end else if (c < S_DL) begin
            cls = AX_INV;
        end else if (c < S_BL) begin
            cls  = AX_DARK;
            near = (c >= S_BL - NEAR_W);
        end else if (c < S_IMG) begin
            cls = AX_BUF;
        end else if (c < S_BR) begin
            cls      = AX_IMG;
            off      = CW'(c - S_IMG + 1);
            edge_hit = (c < S_IMG + EDGE_W) || (c >= S_BR - EDGE_W);
        end else if (c < S_DR) begin
            cls = AX_BUF;
        end else if (c < S_TB) begin
            cls  = AX_DARK;
            near = (c < S_DR + NEAR_W);
        end else if (c < S_TL) begin
            cls = AX_TEST;
        end
    end

endmodule

// File: rtl/ccd_row_class.sv
module ccd_row_class
    import ccd_tag_pkg::*;
#(
    parameter int DARK_TOP = 20,
    parameter int BUF_H    = 1,
    parameter int IMG_H    = 4096,
    parameter int DARK_BOT = 10,
    parameter int NEAR_W   = 2,
    parameter int EDGE_W   = 2,
    parameter int RW       = 13
) (
    input  logic [RW-1:0] row,
    output axis_e         cls,
    output logic          near,
    output logic          edge_hit,
    output logic [RW-1:0] off
);

    localparam int S_BT  = DARK_TOP;
    localparam int S_IMG = S_BT + BUF_H;
    localparam int S_BB  = S_IMG + IMG_H;
    localparam int S_DB  = S_BB + BUF_H;
    localparam int S_END = S_DB + DARK_BOT;

    int r;

    always_comb begin
        r        = int'(row);
        cls      = AX_INV;
        near     = 1'b0;
        edge_hit = 1'b0;
        off      = '0;
        if (r < S_BT) begin
            cls  = AX_DARK;
            near = (r >= S_BT - NEAR_W);
        end else if (r < S_IMG) begin
            cls = AX_BUF;
        end else if (r < S_BB) begin
            cls      = AX_IMG;
            off      = RW'(r - S_IMG + 1);
            edge_hit = (r < S_IMG + EDGE_W) || (r >= S_BB - EDGE_W);
        end else if (r < S_DB) begin
            cls = AX_BUF;
        end else if (r < S_END) begin
            cls  = AX_DARK;
            near = (r < S_DB + NEAR_W);
        end
    end

endmodule

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
    import ccd_tag_pkg::*;
#(
    parameter int LEAD_INV = 11,
    parameter int TEST_W   = 1,
    parameter int GAP_INV  = 3,
    parameter int DARK_L   = 20,
    parameter int BUF_W    = 1,
    parameter int IMG_W    = 4096,
    parameter int DARK_R   = 9,
    parameter int TAIL_INV = 2,
    parameter int DARK_TOP = 20,
    parameter int BUF_H    = 1,
    parameter int IMG_H    = 4096,
    parameter int DARK_BOT = 10,
    parameter int NEAR_W   = 2,
    parameter int EDGE_W   = 2,
    localparam int COLS_TOTAL = LEAD_INV + TEST_W + GAP_INV + DARK_L + BUF_W + IMG_W
                              + BUF_W + DARK_R + TEST_W + TAIL_INV,
    localparam int ROWS_TOTAL = DARK_TOP + BUF_H + IMG_H + BUF_H + DARK_BOT,
    localparam int CW = $clog2(COLS_TOTAL + 1),
    localparam int RW = $clog2(ROWS_TOTAL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_stb,
    input  logic          line_start,
    input  logic          frame_start,
    output logic          out_valid,
    output logic [RW-1:0] row_idx,
    output logic [CW-1:0] col_idx,
    output logic [2:0]    region,
    output logic          flag_image,
    output logic          flag_dark,
    output logic          flag_buffer,
    output logic          flag_test,
    output logic          flag_invalid,
    output logic          near_dark,
    output logic          defect_edge,
    output logic [CW-1:0] img_x,
    output logic [RW-1:0] img_y,
    output logic          short_line
);

    localparam int TEST_A_COL = LEAD_INV;
    localparam int TEST_B_COL = COLS_TOTAL - TAIL_INV - TEST_W;

    typedef struct packed {
        logic          valid;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        region_e       rgn;
        logic          near;
        logic          edge_hit;
        logic [CW-1:0] ix;
        logic [RW-1:0] iy;
    } tag_t;

    tag_t tag_d, tag_q;

    logic [RW-1:0] pos_row;
    logic [CW-1:0] pos_col;
    axis_e         c_cls, r_cls;
    logic          c_near, r_near, c_edge, r_edge;
    logic [CW-1:0] c_off;
    logic [RW-1:0] r_off;

    ccd_pos_counter #(
        .COLS (COLS_TOTAL),
        .ROWS (ROWS_TOTAL),
        .CW   (CW),
        .RW   (RW)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_stb     (pix_stb),
        .line_start  (line_start),
        .frame_start (frame_start),
        .pos_row     (pos_row),
        .pos_col     (pos_col),
        .short_line  (short_line)
    );

    ccd_col_class #(
        .LEAD_INV (LEAD_INV),
        .TEST_W   (TEST_W),
        .GAP_INV  (GAP_INV),
        .DARK_L   (DARK_L),
        .BUF_W    (BUF_W),
        .IMG_W    (IMG_W),
        .DARK_R   (DARK_R),
        .NEAR_W   (NEAR_W),
        .EDGE_W   (EDGE_W),
        .CW       (CW)
    ) u_col (
        .col      (pos_col),
        .cls      (c_cls),
        .near     (c_near),
        .edge_hit (c_edge),
        .off      (c_off)
    );

    ccd_row_class #(
        .DARK_TOP (DARK_TOP),
        .BUF_H    (BUF_H),
        .IMG_H    (IMG_H),
        .DARK_BOT (DARK_BOT),
        .NEAR_W   (NEAR_W),
        .EDGE_W   (EDGE_W),
        .RW       (RW)
    ) u_row (
        .row      (pos_row),
        .cls      (r_cls),
        .near     (r_near),
        .edge_hit (r_edge),
        .off      (r_off)
    );

    always_comb begin
        tag_d       = tag_q;
        tag_d.valid = pix_stb;
        if (pix_stb) begin
            tag_d.row = pos_row;
            tag_d.col = pos_col;
            if (c_cls == AX_INV || r_cls == AX_INV)       tag_d.rgn = RGN_INVALID;
            else if (c_cls == AX_TEST)                     tag_d.rgn = RGN_TEST;
            else if (c_cls == AX_DARK || r_cls == AX_DARK) tag_d.rgn = RGN_DARK;
            else if (c_cls == AX_BUF || r_cls == AX_BUF)   tag_d.rgn = RGN_BUFFER;
            else                                           tag_d.rgn = RGN_IMAGE;
            tag_d.near     = (tag_d.rgn == RGN_DARK) && (c_near || r_near);
            tag_d.edge_hit = (tag_d.rgn == RGN_IMAGE) && (c_edge || r_edge);
            tag_d.ix       = (tag_d.rgn == RGN_IMAGE) ? c_off : '0;
            tag_d.iy       = (tag_d.rgn == RGN_IMAGE) ? r_off : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign out_valid    = tag_q.valid;
    assign row_idx      = tag_q.row;
    assign col_idx      = tag_q.col;
    assign region       = tag_q.rgn;
    assign flag_image   = tag_q.valid && (tag_q.rgn == RGN_IMAGE);
    assign flag_dark    = tag_q.valid && (tag_q.rgn == RGN_DARK);
    assign flag_buffer  = tag_q.valid && (tag_q.rgn == RGN_BUFFER);
    assign flag_test    = tag_q.valid && (tag_q.rgn == RGN_TEST);
    assign flag_invalid = tag_q.valid && (tag_q.rgn == RGN_INVALID);
    assign near_dark    = tag_q.valid && tag_q.near;
    assign defect_edge  = tag_q.valid && tag_q.edge_hit;
    assign img_x        = tag_q.ix;
    assign img_y        = tag_q.iy;

endmodule

// File: rtl/ccd_region_tagger_chk.sv
module ccd_region_tagger_chk #(
    parameter int COLS   = 4145,
    parameter int ROWS   = 4128,
    parameter int IMG_W  = 4096,
    parameter int IMG_H  = 4096,
    parameter int TEST_A = 11,
    parameter int TEST_B = 4142,
    parameter int TEST_W = 1,
    parameter int CW     = 13,
    parameter int RW     = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_stb,
    input logic          line_start,
    input logic          frame_start,
    input logic          out_valid,
    input logic [RW-1:0] row_idx,
    input logic [CW-1:0] col_idx,
    input logic          flag_image,
    input logic          flag_dark,
    input logic          flag_test,
    input logic          near_dark,
    input logic          defect_edge,
    input logic [CW-1:0] img_x,
    input logic [RW-1:0] img_y,
    input logic          short_line
);

    a_r2_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && int'(col_idx) < COLS && pix_stb && !line_start && !frame_start)
        |=> (col_idx == $past(col_idx) + CW'(1)));

    a_r2_line_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(line_start)) |-> (col_idx == '0));

    a_r3_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(frame_start)) |-> (row_idx == '0 && col_idx == '0));

    a_r7_test_cols: assert property (@(posedge clk) disable iff (!rst_n)
        flag_test |-> ((int'(col_idx) >= TEST_A && int'(col_idx) < TEST_A + TEST_W) ||
                       (int'(col_idx) >= TEST_B && int'(col_idx) < TEST_B + TEST_W)));

    a_r8_near_is_dark: assert property (@(posedge clk) disable iff (!rst_n)
        near_dark |-> flag_dark);

    a_r9_edge_is_image: assert property (@(posedge clk) disable iff (!rst_n)
        defect_edge |-> flag_image);

    a_r10_coord_range: assert property (@(posedge clk) disable iff (!rst_n)
        flag_image |-> (int'(img_x) >= 1 && int'(img_x) <= IMG_W &&
                        int'(img_y) >= 1 && int'(img_y) <= IMG_H));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(col_idx) <= COLS) && (int'(row_idx) <= ROWS));

    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        short_line |=> short_line);

endmodule

bind ccd_region_tagger ccd_region_tagger_chk #(
    .COLS   (COLS_TOTAL),
    .ROWS   (ROWS_TOTAL),
    .IMG_W  (IMG_W),
    .IMG_H  (IMG_H),
    .TEST_A (TEST_A_COL),
    .TEST_B (TEST_B_COL),
    .TEST_W (TEST_W),
    .CW     (CW),
    .RW     (RW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_stb     (pix_stb),
    .line_start  (line_start),
    .frame_start (frame_start),
    .out_valid   (out_valid),
    .row_idx     (row_idx),
    .col_idx     (col_idx),
    .flag_image  (flag_image),
    .flag_dark   (flag_dark),
    .flag_test   (flag_test),
    .near_dark   (near_dark),
    .defect_edge (defect_edge),
    .img_x       (img_x),
    .img_y       (img_y),
    .short_line  (short_line)
);

// File: tb/ccd_region_tagger_tb.sv
module ccd_region_tagger_tb;

    localparam int NCOL = 4145;
    localparam int NROW = 4128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_stb = 1'b0, line_start = 1'b0, frame_start = 1'b0;
    logic        out_valid;
    logic [12:0] row_idx, col_idx, img_x, img_y;
    logic [2:0]  region;
    logic        flag_image, flag_dark, flag_buffer, flag_test, flag_invalid;
    logic        near_dark, defect_edge, short_line;

    int tests = 0;
    int fails = 0;

    typedef struct {
        int row; int col; int rgn; int near; int edg; int ix; int iy;
    } exp_t;
    exp_t sb[$];

    int mrow = 0, mcol = 0;
    bit mstart = 0;

    always #4 clk = ~clk;

    ccd_region_tagger u_dut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .line_start(line_start),
        .frame_start(frame_start), .out_valid(out_valid), .row_idx(row_idx),
        .col_idx(col_idx), .region(region), .flag_image(flag_image),
        .flag_dark(flag_dark), .flag_buffer(flag_buffer), .flag_test(flag_test),
        .flag_invalid(flag_invalid), .near_dark(near_dark), .defect_edge(defect_edge),
        .img_x(img_x), .img_y(img_y), .short_line(short_line)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected tag written from the layouts in R4, R5, R6, R8, R9, R10, R11
    function automatic exp_t classify(int r, int c);
        exp_t e;
        int cc, rc;  // 0 inv, 1 test, 2 dark, 3 buf, 4 img
        if (c >= 4145 || c < 11) cc = 0;
        else if (c == 11) cc = 1;
        else if (c < 15) cc = 0;
        else if (c < 35) cc = 2;
        else if (c == 35) cc = 3;
        else if (c < 4132) cc = 4;
        else if (c == 4132) cc = 3;
        else if (c < 4142) cc = 2;
        else if (c == 4142) cc = 1;
        else cc = 0;
        if (r >= 4128) rc = 0;
        else if (r < 20) rc = 2;
        else if (r == 20) rc = 3;
        else if (r < 4117) rc = 4;
        else if (r == 4117) rc = 3;
        else rc = 2;
        e.row = r; e.col = c;
        if (cc == 0 || rc == 0) e.rgn = 4;
        else if (cc == 1) e.rgn = 3;
        else if (cc == 2 || rc == 2) e.rgn = 1;
        else if (cc == 3 || rc == 3) e.rgn = 2;
        else e.rgn = 0;
        e.near = (e.rgn == 1) && (c == 33 || c == 34 || c == 4133 || c == 4134 ||
                                  r == 18 || r == 19 || r == 4118 || r == 4119);
        e.ix = (e.rgn == 0) ? c - 35 : 0;
        e.iy = (e.rgn == 0) ? r - 20 : 0;
        e.edg = (e.rgn == 0) && (e.ix <= 2 || e.ix >= 4095 || e.iy <= 2 || e.iy >= 4095);
        return e;
    endfunction

    task automatic put(bit stb, bit ls, bit fs);
        @(negedge clk);
        pix_stb = stb; line_start = ls; frame_start = fs;
        if (fs) begin mrow = 0; mcol = 0; mstart = 0; end
        if (ls) begin
            if (mstart && mrow != NROW) mrow++;
            mcol = 0; mstart = 1;
        end
        if (stb) begin
            sb.push_back(classify(mrow, mcol));
            if (mcol != NCOL) mcol++;
        end
    endtask

    task automatic run_line(int n);
        put(1, 1, 0);
        for (int i = 1; i < n; i++) put(1, 0, 0);
    endtask

    task automatic skip_to(int target);
        while (mrow < target - 1) put(0, 1, 0);
        run_line(NCOL);
    endtask

    // Monitor: result of a strobe at edge k is visible at the falling edge after k
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                chk("R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R2 col", int'(col_idx), e.col);
                chk("R3 row", int'(row_idx), e.row);
                chk("R4 R5 R6 R7 R11 region", int'(region), e.rgn);
                chk("R6 flags", int'({flag_invalid, flag_test, flag_buffer, flag_dark, flag_image}),
                    1 << e.rgn);
                chk("R8 near_dark", int'(near_dark), e.near);
                chk("R9 defect_edge", int'(defect_edge), e.edg);
                chk("R10 img_x", int'(img_x), e.ix);
                chk("R10 img_y", int'(img_y), e.iy);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk("watchdog", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 short_line", int'(short_line), 0);
        chk("R1 flags", int'({flag_invalid, flag_test, flag_buffer, flag_dark, flag_image,
                              near_dark, defect_edge}), 0);
        chk("R1 counters", int'(row_idx) + int'(col_idx) + int'(img_x) + int'(img_y), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(out_valid) + int'(short_line), 0);

        put(0, 0, 1);
        // Row 0 with three extra strobes past column 4144 (R11 column saturation)
        run_line(NCOL + 3);
        run_line(NCOL);                 // row 1, complete
        put(0, 1, 0);                   // ends complete row 1
        put(0, 0, 0);
        chk("R12 clear after full line", int'(short_line), 0);
        for (int i = 0; i < 5; i++) put(1, 0, 0);   // row 2 only partly read
        put(0, 1, 0);
        put(0, 0, 0);
        chk("R12 set after short line", int'(short_line), 1);

        skip_to(19);    // near dark row (R8)
        run_line(NCOL); // row 20 buffer (R5)
        run_line(NCOL); // row 21 image edge (R9)
        skip_to(23);    // interior image row, test columns in image rows (R7)
        skip_to(4116);  // last image row (R9, R10)
        run_line(NCOL); // row 4117 buffer
        run_line(NCOL); // row 4118 near dark
        skip_to(4127);  // last row
        run_line(5);    // row 4128 beyond frame (R11)
        run_line(3);    // still 4128, no wrap (R11)
        put(0, 0, 0);
        chk("R12 sticky", int'(short_line), 1);

        // R3: frame and line start together, strobe tagged row 0 col 0
        put(1, 1, 1);
        put(1, 0, 0);
        put(0, 0, 0);
        put(0, 0, 0);
        chk("R2 scoreboard drained", sb.size(), 0);

        rst_n = 1'b0;
        put(0, 0, 0);
        put(0, 0, 0);
        chk("R1 R12 short_line cleared by reset", int'(short_line), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule